// File: doc/BRIEF.md
# Chainable Dual 8-bit Down-Counting Timer

The block holds two 8-bit down-counters, a low timer and a high timer. Each has a reload value, a running count and a mode byte. The mode byte holds a count enable, a load enable and a 3-bit source code. A counter steps down once for each count event. When a count event arrives while the counter is at zero, the counter reloads and the timer emits a one-cycle underflow pulse. A counter is preset only by holding its load enable. Reset clears it, but writing the reload value does not touch it.

When the high timer is set to the chain source, it takes the low timer's borrows as its count events. The pair then behaves as one 16-bit counter, with the reload value split into a high byte and a low byte, and it divides the tick input by that 16-bit value plus one. Each underflow sets a sticky request flag. The interrupt line is the OR of the flags whose enable bits are set. The control word also holds a 3-bit priority level, which the block drives out unchanged to an external interrupt controller.

Software reaches every register through a single-cycle write strobe and a registered read port.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset, every register reads 0 (both modes, both reload values, both counts and the control word), and irq, irq_level, uf_lo and uf_hi are 0.
- R2: The register addresses are 0 low mode, 1 high mode, 2 low reload, 3 high reload, 4 low count, 5 high count and 6 control. Addresses 4 and 5 are read-only. bus_rdata shows the register selected by bus_addr, taken at the next clock edge.
- R3: In a mode byte, bit 7 is count enable, bit 6 is load enable and bits 2..0 are the source code. Code 000 makes every cycle with tick high a count event. Code 011 chains the high timer to the low timer. Every other code, including 011 on the low timer, produces no count events.
- R4: While load enable is 1, the counter copies its reload value on every clock. Writing the reload value alone leaves the counter unchanged.
- R5: When load enable and a count event fall in the same cycle, the load wins, so no decrement and no underflow occur.
- R6: A count event at a nonzero count decrements the counter. A count event at zero reloads the counter and drives the timer's underflow output (uf_lo or uf_hi) high for one cycle. A single timer therefore underflows once every (reload+1) count events.
- R7: In chained mode, the low timer wraps from 0 to 0xFF while the high count is nonzero, and both timers reload together when the 16-bit value is 0. A 16-bit reload value V gives one uf_hi pulse every V+1 ticks, so V = 0x752F gives one pulse every 30000 ticks.
- R8: An underflow sets its request flag whatever its enable bit is. The low flag is control bit 0 and the high flag is bit 1. Writing 1 to a flag bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over the clear.
- R9: irq is 1 exactly when some flag is set together with its enable (bit 8 for the low timer, bit 9 for the high timer). irq rises on the same edge that sets the flag.
- R10: Control bits 14..12 hold a priority level that reads back and drives irq_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Peripheral clock tick, count source for code 000 |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed priority level |
| uf_lo | output | 1 | Low timer underflow pulse |
| uf_hi | output | 1 | High timer underflow pulse |

## Verification
The bench predicts the exact clock of every underflow pulse from the reload value and the cycle on which counting was enabled, both for a single timer and for the 30000-tick chained division. A design that reloads from the reload value inside the chain, instead of wrapping to 0xFF, gives a period of 118×48 ticks rather than 30000, and a design that is one cycle early or late on reload shows up as a shifted pulse. The bench holds load enable and count enable together to catch a design that lets counting win. It selects codes that must not count, to catch a decoder that treats unused codes as the tick. It also runs underflows with the enable bit off, to catch a design that gates the sticky flag instead of the interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int SEL_W = 3;

  localparam logic [AW-1:0] A_MODE_LO = 3'd0;
  localparam logic [AW-1:0] A_MODE_HI = 3'd1;
  localparam logic [AW-1:0] A_BASE_LO = 3'd2;
  localparam logic [AW-1:0] A_BASE_HI = 3'd3;
  localparam logic [AW-1:0] A_CNT_LO  = 3'd4;
  localparam logic [AW-1:0] A_CNT_HI  = 3'd5;
  localparam logic [AW-1:0] A_CTRL    = 3'd6;

  localparam logic [SEL_W-1:0] SEL_TICK  = 3'b000;
  localparam logic [SEL_W-1:0] SEL_CHAIN = 3'b011;

  localparam int B_CNT_EN  = 7;
  localparam int B_LOAD_EN = 6;
  localparam int B_EN_LO   = 8;
  localparam int B_EN_HI   = 9;
  localparam int B_LVL_LSB = 12;
  localparam int LVL_W     = 3;

  typedef struct packed {
    logic             cnt_en;
    logic             load_en;
    logic [SEL_W-1:0] sel;
  } mode_t;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
#(
  parameter bit CHAIN_OK = 1'b0
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  input  logic             chain_in,
  output logic             evt
);
  always_comb begin
    case (sel)
      SEL_TICK:  evt = tick;
      SEL_CHAIN: evt = CHAIN_OK ? chain_in : 1'b0;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] base,
  input  logic         load_en,
  input  logic         cnt_en,
  input  logic         src_evt,
  input  logic         wrap_all,
  output logic [W-1:0] cnt_q,
  output logic         borrow,
  output logic         uf_q
);
  logic step;
  logic at_zero;

  assign step    = cnt_en && src_evt;
  assign at_zero = (cnt_q == '0);
  assign borrow  = !load_en && step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= borrow;
      if (load_en) begin
        cnt_q <= base;
      end else if (step) begin
        if (at_zero) cnt_q <= wrap_all ? {W{1'b1}} : base;
        else         cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (cnt_q == $past(base)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step) |=> $stable(cnt_q));

  // R6
  uf_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(uf_q) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic [NT-1:0]    set,
  output logic [NT-1:0]    flag_q,
  output logic [NT-1:0]    en_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic             irq_q
);
  logic [NT-1:0] clr;
  logic [NT-1:0] flag_d;
  logic [NT-1:0] en_d;

  assign clr    = wr ? wdata[NT-1:0] : '0;
  assign flag_d = (flag_q & ~clr) | set;
  assign en_d   = wr ? wdata[B_EN_LO +: NT] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      if (wr) lvl_q <= wdata[B_LVL_LSB +: LVL_W];
      irq_q  <= |(flag_d & en_d);
    end
  end

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (|(flag_q & en_q)));

  // R8
  sticky_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q[0] && !(wr && wdata[0])) |=> flag_q[0]);

  // R8
  sticky_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q[1] && !(wr && wdata[1])) |=> flag_q[1]);
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq,
  output logic [LVL_W-1:0] irq_level,
  output logic             uf_lo,
  output logic             uf_hi
);
  localparam int NT = 2;
  localparam int MW = 8;

  logic [MW-1:0] mode_q [NT];
  logic [W-1:0]  base_q [NT];
  logic [W-1:0]  cnt    [NT];
  logic [NT-1:0] borrow;
  logic [NT-1:0] uf;
  logic [NT-1:0] evt;
  logic [NT-1:0] wrap;
  logic [NT-1:0] flag_q;
  logic [NT-1:0] en_q;
  logic [LVL_W-1:0] lvl_q;
  logic          chained;
  logic          ctrl_wr;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] ctrl_word;

  assign chained = mode_q[1][B_CNT_EN] && (mode_q[1][SEL_W-1:0] == SEL_CHAIN);
  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) begin
        mode_q[i] <= '0;
        base_q[i] <= '0;
      end
    end else if (bus_we) begin
      case (bus_addr)
        A_MODE_LO: mode_q[0] <= bus_wdata[MW-1:0];
        A_MODE_HI: mode_q[1] <= bus_wdata[MW-1:0];
        A_BASE_LO: base_q[0] <= bus_wdata[W-1:0];
        A_BASE_HI: base_q[1] <= bus_wdata[W-1:0];
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_tmr
      if (g == 0) begin : g_low
        assign wrap[g] = chained && (cnt[1] != '0);
        tmr_src_sel #(.CHAIN_OK(1'b0)) u_sel (
          .sel(mode_q[g][SEL_W-1:0]), .tick(tick), .chain_in(1'b0), .evt(evt[g]));
      end else begin : g_high
        assign wrap[g] = 1'b0;
        tmr_src_sel #(.CHAIN_OK(1'b1)) u_sel (
          .sel(mode_q[g][SEL_W-1:0]), .tick(tick), .chain_in(borrow[g-1]), .evt(evt[g]));
      end
      tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .base(base_q[g]),
        .load_en(mode_q[g][B_LOAD_EN]), .cnt_en(mode_q[g][B_CNT_EN]),
        .src_evt(evt[g]), .wrap_all(wrap[g]),
        .cnt_q(cnt[g]), .borrow(borrow[g]), .uf_q(uf[g]));
    end
  endgenerate

  tmr_irq_ctrl #(.NT(NT)) u_irq (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(bus_wdata), .set(borrow),
    .flag_q(flag_q), .en_q(en_q), .lvl_q(lvl_q), .irq_q(irq));

  always_comb begin
    ctrl_word = '0;
    ctrl_word[NT-1:0] = flag_q;
    ctrl_word[B_EN_LO +: NT] = en_q;
    ctrl_word[B_LVL_LSB +: LVL_W] = lvl_q;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_MODE_LO: rd_mux[MW-1:0] = mode_q[0];
      A_MODE_HI: rd_mux[MW-1:0] = mode_q[1];
      A_BASE_LO: rd_mux[W-1:0]  = base_q[0];
      A_BASE_HI: rd_mux[W-1:0]  = base_q[1];
      A_CNT_LO:  rd_mux[W-1:0]  = cnt[0];
      A_CNT_HI:  rd_mux[W-1:0]  = cnt[1];
      A_CTRL:    rd_mux         = ctrl_word;
      default:   rd_mux         = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign uf_lo     = uf[0];
  assign uf_hi     = uf[1];
  assign irq_level = lvl_q;

  // R7
  chain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (chained && !mode_q[1][B_LOAD_EN] && !borrow[0]) |=> $stable(cnt[1]));

  // R7
  chain_joint_uf_chk: assert property (@(posedge clk) disable iff (rst)
    (chained && borrow[1]) |-> borrow[0]);
endmodule

// File: tb/tmr_pair_top_test.sv
module tmr_pair_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  logic [2:0]  irq_level;
  logic        uf_lo, uf_hi;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit watch_lo = 0, watch_hi = 0, want_irq = 0;

  typedef struct { int at; bit hi; } exp_t;
  exp_t exp_q[$];

  tmr_pair_top uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .irq_level(irq_level), .uf_lo(uf_lo), .uf_hi(uf_hi));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int e);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    e = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected pulses as the design produces them
  always @(negedge clk) begin
    if (!rst && ((watch_lo && uf_lo) || (watch_hi && uf_hi))) begin
      if (exp_q.size() == 0) begin
        check(uf_hi ? "R6/R7 unexpected uf_hi" : "R5/R6 unexpected uf_lo", cyc, -1);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        check(x.hi ? "R7 uf_hi cycle" : "R6 uf_lo cycle", cyc, x.at);
        if (want_irq) check("R9 irq with uf_hi", int'(irq), 1);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int e, v, v_full;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R2 addresses
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reset readback", v, 0);
    end
    check("R1 irq", int'(irq), 0);
    check("R1 irq_level", int'(irq_level), 0);
    check("R1 uf", int'({uf_lo, uf_hi}), 0);

    // R2/R4 reload write readback, counter untouched
    wr(3'd2, 16'h0005, e);
    wr(3'd3, 16'h00A5, e);
    rd(3'd2, v); check("R2 low reload", v, 5);
    rd(3'd3, v); check("R2 high reload", v, 16'hA5);
    rd(3'd4, v); check("R4 base write leaves count", v, 0);
    wr(3'd4, 16'h0033, e);
    rd(3'd4, v); check("R2 count is read-only", v, 0);

    // R6 single timer, period 6
    watch_lo = 1;
    wr(3'd0, 16'h0040, e);
    wr(3'd0, 16'h0080, e);
    for (int n = 0; n < 4; n++) exp_q.push_back('{e + 6 + 6*n, 1'b0});
    wait_to(e + 26);
    wr(3'd0, 16'h0000, v);
    repeat (8) @(negedge clk);
    check("R6 all low pulses seen", exp_q.size(), 0);
    rd(3'd6, v);
    check("R8 low flag set with enable off", v & 16'h0003, 1);
    check("R9 irq stays low when disabled", int'(irq), 0);

    // R8 W1C, R10 level
    wr(3'd6, 16'h5001, e);
    rd(3'd6, v);
    check("R8 flag cleared / R10 level", v, 16'h5000);
    check("R10 irq_level port", int'(irq_level), 5);

    // R3 non-counting codes
    wr(3'd2, 16'h0009, e);
    wr(3'd0, 16'h0040, e);
    wr(3'd0, 16'h0081, e);
    repeat (20) @(negedge clk);
    rd(3'd4, v); check("R3 code 001 does not count", v, 9);
    wr(3'd0, 16'h0083, e);
    repeat (20) @(negedge clk);
    rd(3'd4, v); check("R3 code 011 on low timer does not count", v, 9);

    // R5 load wins over counting
    wr(3'd0, 16'h00C0, e);
    repeat (30) @(negedge clk);
    rd(3'd4, v); check("R5 load precedence holds count", v, 9);
    wr(3'd0, 16'h0000, e);
    rd(3'd6, v); check("R5 no underflow flag", v & 16'h0003, 0);
    watch_lo = 0;

    // R7 chained 16-bit divide by 30000
    v_full = 16'h752F;
    wr(3'd2, 16'h002F, e);
    wr(3'd3, 16'h0075, e);
    wr(3'd6, 16'h4203, e);
    wr(3'd0, 16'h0040, e);
    wr(3'd1, 16'h0043, e);
    watch_hi = 1; want_irq = 1;
    wr(3'd0, 16'h0080, e);
    exp_q.push_back('{e + v_full + 1, 1'b1});
    exp_q.push_back('{e + 2*v_full + 2, 1'b1});
    wr(3'd1, 16'h0083, v);
    wait_to(e + 99);
    rd(3'd4, v); check("R7 low byte mid-run", v, (v_full - 99) & 8'hFF);
    rd(3'd5, v); check("R7 high byte mid-run", v, (v_full - 100) >> 8);
    wait_to(e + 2*v_full + 8);
    check("R7 all high pulses seen", exp_q.size(), 0);
    rd(3'd6, v); check("R8 both flags set in chain", v & 16'h0003, 3);
    check("R9 irq from high flag", int'(irq), 1);
    wr(3'd6, 16'h4202, e);
    wr(3'd1, 16'h0000, e);
    wr(3'd0, 16'h0000, e);
    watch_hi = 0; want_irq = 0;
    rd(3'd6, v); check("R8 high cleared, low remains", v & 16'h0003, 1);
    check("R9 irq low with only disabled flag", int'(irq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule